// File: doc/BRIEF.md
# Shift-Register Clock Divider Pair with Cascaded Post-Division

This block holds the programmable divide chain of a frequency synthesizer. A reference divider and a feedback divider each count with a linear feedback shift register, not a binary counter. Every time a divider reaches its fixed terminal state, it emits a one-cycle tick, flips its square-wave output and reloads itself from a register that software writes. The reload value selects the divisor. To divide by N, software loads the state that sits N-1 steps ahead of the terminal state in the register's own sequence.

Two cascaded post-dividers divide the synthesized (VCO-side) advance stream. Their settings share one register of two 3-bit fields. Each field holds eight minus the divisor of its stage. One clock runs the whole block. A per-divider advance enable marks the input edges it divides: the reference stream for the reference divider, and the VCO stream for the feedback and post dividers. A single write port loads the three registers.

Top module: `lfsr_clkdiv`

## Requirements
- R1: While reset is held, and after it until the first advance, every tick and every divided clock output is 0.
- R2: The reference divider is 6 bits wide. Its terminal state is 0x3F. From state 0x00 it steps to 0x3F. From any other state s it steps to {s[4:0], ~(s[5]^s[4])}. Reload 0x3F gives a divisor of 1, 0x20 gives 3, 0x07 gives 62, 0x03 gives 63 and 0x01 gives 64: `ref_tick` pulses once every N advances.
- R3: The feedback divider is 8 bits wide. Its terminal state is 0x01, and state s steps to {s[6:0], ~(s[7]^s[3]^s[2]^s[1])}. Reload 0x00 gives a divisor of 2, 0x80 gives 3 and 0xC0 gives 4. Divisors up to 160 are reached the same way, and `fb_tick` pulses once every N advances.
- R4: Each divided clock output inverts on the cycle its tick is high and holds otherwise. After the k-th tick since reset, it equals k modulo 2, so its period is twice the divisor.
- R5: A reload write that lands part way through a division does not change the division in progress. It takes effect at the next terminal-state reload.
- R6: The post-divide register holds (8 - second divisor) in bits 5:3 and (8 - first divisor) in bits 2:0. `pix_tick` pulses once every first × second feedback-side advances. Each divisor ranges from 1 to 8.
- R7: The post-divide register is sampled only when the whole cascade wraps. A transient value written and then overwritten within one output period never affects the output period.
- R8: With its advance enable low, a divider holds its state, raises no tick and keeps its clock output. Its period is counted in advances, not in clock cycles.
- R9: Register writes are selected by `wr_sel`: 0 selects the reference reload (data bits 5:0), 1 selects the feedback reload (bits 7:0) and 2 selects the post-divide register (bits 5:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 reference, 1 feedback, 2 post-divide, 3 none |
| wr_data | input | 8 | Write data |
| ref_adv | input | 1 | Reference input edge: advances the reference divider |
| fb_adv | input | 1 | VCO input edge: advances the feedback and post dividers |
| ref_tick | output | 1 | One-cycle pulse each reference division |
| ref_clk | output | 1 | Divided reference clock, period 2N |
| fb_tick | output | 1 | One-cycle pulse each feedback division |
| fb_clk | output | 1 | Divided feedback clock |
| pix_tick | output | 1 | One-cycle pulse each post-divided period |
| pix_clk | output | 1 | Post-divided clock |

## Verification
The bench computes each reload value on its own, by walking the shift-register sequence backwards from the terminal state. It then measures tick periods at both extremes of each divider. A wrong tap or terminal state shows up as a period that is off by a scattered, non-monotonic amount. A missing 0x00-to-0x3F jump loses the 64 divisor. The bench rewrites a reload mid-count. A design that loads at write time would shorten that one period. The bench also sends the two-write post-divide sequence inside one output period. A design that sampled the register at every stage wrap would produce a 49-cycle period instead of 16 then 64. Halving the VCO advance rate and freezing the reference advance expose a design that counts clock cycles instead of advances.

// File: rtl/lfsr_clkdiv_pkg.sv
package lfsr_clkdiv_pkg;

    // Reference divider: 6-bit, XNOR taps on bits 5 and 4, extra 0 -> terminal step.
    localparam int              REF_W     = 6;
    localparam logic [REF_W-1:0] REF_TERM = 6'h3F;
    localparam logic [REF_W-1:0] REF_TAPS = 6'h30;
    localparam bit              REF_JUMP  = 1'b1;

    // Feedback divider: 8-bit, XNOR taps on bits 7, 3, 2, 1.
    localparam int              FB_W      = 8;
    localparam logic [FB_W-1:0] FB_TERM   = 8'h01;
    localparam logic [FB_W-1:0] FB_TAPS   = 8'h8E;
    localparam bit              FB_JUMP   = 1'b0;

    // Post-divider fields.
    localparam int PD_W    = 3;
    localparam int POST_W  = 2 * PD_W;
    localparam int DATA_W  = 8;

    typedef enum logic [1:0] {
        SEL_REF  = 2'd0,
        SEL_FB   = 2'd1,
        SEL_POST = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;

    // Field order matters: upper field is the second stage.
    typedef struct packed {
        logic [PD_W-1:0] stage2_code;
        logic [PD_W-1:0] stage1_code;
    } post_cfg_t;

endpackage

// File: rtl/lfsr_divider.sv
module lfsr_divider #(
    parameter int           W    = 6,
    parameter logic [W-1:0] TERM = '1,
    parameter logic [W-1:0] TAPS = '0,
    parameter bit           JUMP = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] reload,
    output logic         tick,
    output logic         div_clk
);

    logic [W-1:0] state;
    logic [W-1:0] nxt;
    logic         at_term;

    assign at_term = (state == TERM);

    always_comb begin
        nxt = {state[W-2:0], ~^(state & TAPS)};
        if (JUMP && (state == '0)) begin
            nxt = TERM;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TERM;
            tick    <= 1'b0;
            div_clk <= 1'b0;
        end else begin
            tick <= adv && at_term;
            if (adv) begin
                state <= at_term ? reload : nxt;
                if (at_term) begin
                    div_clk <= ~div_clk;
                end
            end
        end
    end

    // R8: no advance, no movement
    a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state));

    // R4: divided clock flips exactly with a tick
    a_r4_clk_on_tick: assert property (@(posedge clk) disable iff (rst)
        tick |-> (div_clk != $past(div_clk)));

    a_r4_clk_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |-> $stable(div_clk));

endmodule

// File: rtl/post_divider.sv
module post_divider
    import lfsr_clkdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adv,
    input  post_cfg_t cfg,
    output logic      tick,
    output logic      div_clk
);

    localparam logic [PD_W-1:0] LAST = '1;

    logic [PD_W-1:0] c1;
    logic [PD_W-1:0] c2;
    logic [PD_W-1:0] act1;
    logic            s1_wrap;
    logic            full_wrap;

    assign s1_wrap   = adv && (c1 == LAST);
    assign full_wrap = s1_wrap && (c2 == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            c1      <= LAST;
            c2      <= LAST;
            act1    <= LAST;
            tick    <= 1'b0;
            div_clk <= 1'b0;
        end else begin
            tick <= full_wrap;
            if (full_wrap) begin
                div_clk <= ~div_clk;
                c1      <= cfg.stage1_code;
                act1    <= cfg.stage1_code;
                c2      <= cfg.stage2_code;
            end else if (s1_wrap) begin
                c1 <= act1;
                c2 <= c2 + 1'b1;
            end else if (adv) begin
                c1 <= c1 + 1'b1;
            end
        end
    end

    // R7: stage-1 setting only changes at a full cascade wrap
    a_r7_cfg_latched: assert property (@(posedge clk) disable iff (rst)
        !full_wrap |=> $stable(act1));

    // R6: second stage only counts first-stage wraps
    a_r6_stage2_hold: assert property (@(posedge clk) disable iff (rst)
        !s1_wrap |=> $stable(c2));

    // R8: no advance, first stage frozen
    a_r8_post_freeze: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(c1));

endmodule

// File: rtl/lfsr_clkdiv.sv
module lfsr_clkdiv
    import lfsr_clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ref_adv,
    input  logic              fb_adv,
    output logic              ref_tick,
    output logic              ref_clk,
    output logic              fb_tick,
    output logic              fb_clk,
    output logic              pix_tick,
    output logic              pix_clk
);

    logic [REF_W-1:0] ref_reload;
    logic [FB_W-1:0]  fb_reload;
    post_cfg_t        post_cfg;
    wsel_e            sel;

    assign sel = wsel_e'(wr_sel);

    // R9: register write decode
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_reload <= REF_TERM;
            fb_reload  <= '0;
            post_cfg   <= '1;
        end else if (wr_en) begin
            case (sel)
                SEL_REF:  ref_reload <= wr_data[REF_W-1:0];
                SEL_FB:   fb_reload  <= wr_data[FB_W-1:0];
                SEL_POST: post_cfg   <= post_cfg_t'(wr_data[POST_W-1:0]);
                default:  ;
            endcase
        end
    end

    lfsr_divider #(
        .W    (REF_W),
        .TERM (REF_TERM),
        .TAPS (REF_TAPS),
        .JUMP (REF_JUMP)
    ) u_ref (
        .clk     (clk),
        .rst     (rst),
        .adv     (ref_adv),
        .reload  (ref_reload),
        .tick    (ref_tick),
        .div_clk (ref_clk)
    );

    lfsr_divider #(
        .W    (FB_W),
        .TERM (FB_TERM),
        .TAPS (FB_TAPS),
        .JUMP (FB_JUMP)
    ) u_fb (
        .clk     (clk),
        .rst     (rst),
        .adv     (fb_adv),
        .reload  (fb_reload),
        .tick    (fb_tick),
        .div_clk (fb_clk)
    );

    post_divider u_post (
        .clk     (clk),
        .rst     (rst),
        .adv     (fb_adv),
        .cfg     (post_cfg),
        .tick    (pix_tick),
        .div_clk (pix_clk)
    );

endmodule

// File: tb/lfsr_clkdiv_bench.sv
module lfsr_clkdiv_bench;

    typedef struct {
        int    period;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       ref_adv = 1'b0;
    logic       fb_adv = 1'b0;
    logic       ref_tick, ref_clk, fb_tick, fb_clk, pix_tick, pix_clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    exp_t q0[$];
    exp_t q1[$];
    exp_t q2[$];
    int last[3];
    bit has[3];
    int tcnt[3];

    always #10 clk = ~clk;

    lfsr_clkdiv u_lfsr_clkdiv (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ref_adv(ref_adv), .fb_adv(fb_adv),
        .ref_tick(ref_tick), .ref_clk(ref_clk), .fb_tick(fb_tick), .fb_clk(fb_clk),
        .pix_tick(pix_tick), .pix_clk(pix_clk)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Reload for divisor n: walk backwards n-1 steps from the terminal state.
    function automatic logic [5:0] ref_code(input int n);
        logic [5:0] s;
        s = 6'h3F;
        for (int i = 1; i < n; i++)
            s = (s == 6'h3F) ? 6'h00 : {s[5] ^ ~s[0], s[5:1]};
        return s;
    endfunction

    function automatic logic [7:0] fb_code(input int n);
        logic [7:0] s;
        s = 8'h01;
        for (int i = 1; i < n; i++)
            s = {~s[0] ^ s[4] ^ s[3] ^ s[2], s[7:1]};
        return s;
    endfunction

    function automatic logic [7:0] post_code(input int p1, input int p2);
        return 8'(((8 - p2) << 3) | (8 - p1));
    endfunction

    // Monitor: measures tick intervals, checks clock parity, pops expectations.
    always @(negedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            errors++;
            $display("FAIL watchdog all-reqs actual=%0d expected<%0d", cyc, 150000);
            summary();
        end
        if (rst) begin
            for (int k = 0; k < 3; k++) begin
                has[k] = 1'b0;
                tcnt[k] = 0;
            end
        end else begin
            for (int k = 0; k < 3; k++) begin
                logic t;
                logic c;
                exp_t e;
                bit got;
                t = (k == 0) ? ref_tick : (k == 1) ? fb_tick : pix_tick;
                c = (k == 0) ? ref_clk  : (k == 1) ? fb_clk  : pix_clk;
                if (t) begin
                    tcnt[k]++;
                    check(c == tcnt[k][0], "R4 clock parity", int'(c), tcnt[k] % 2);
                    if (has[k]) begin
                        got = 1'b0;
                        case (k)
                            0: if (q0.size() > 0) begin e = q0.pop_front(); got = 1'b1; end
                            1: if (q1.size() > 0) begin e = q1.pop_front(); got = 1'b1; end
                            default: if (q2.size() > 0) begin e = q2.pop_front(); got = 1'b1; end
                        endcase
                        if (got)
                            check(cyc - last[k] == e.period, e.req, cyc - last[k], e.period);
                    end
                    last[k] = cyc;
                    has[k] = 1'b1;
                end
            end
        end
    end

    task automatic do_reset();
        ref_adv = 1'b0;
        fb_adv = 1'b0;
        wr_en = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_empty(input bit alt);
        while (q0.size() + q1.size() + q2.size() != 0) begin
            @(negedge clk);
            if (alt) fb_adv = ~fb_adv;
        end
    endtask

    task automatic run_seg(input int rn, input int fn, input int p1, input int p2, input int reps);
        do_reset();
        wr(2'd0, {2'b00, ref_code(rn)});
        wr(2'd1, fb_code(fn));
        wr(2'd2, post_code(p1, p2));
        for (int i = 0; i < reps; i++) begin
            q0.push_back('{rn, "R2 ref period"});
            q1.push_back('{fn, "R3 fb period"});
            q2.push_back('{p1 * p2, "R6 post period"});
        end
        @(negedge clk);
        ref_adv = 1'b1;
        fb_adv = 1'b1;
        wait_empty(1'b0);
    endtask

    initial begin
        int t0;
        logic c0;

        // R2 / R3: encodings derived backwards match the stated reload values
        check(ref_code(1) == 6'h3F, "R2 code d1", int'(ref_code(1)), 'h3F);
        check(ref_code(3) == 6'h20, "R2 code d3", int'(ref_code(3)), 'h20);
        check(ref_code(62) == 6'h07, "R2 code d62", int'(ref_code(62)), 'h07);
        check(ref_code(64) == 6'h01, "R2 code d64", int'(ref_code(64)), 'h01);
        check(fb_code(2) == 8'h00, "R3 code d2", int'(fb_code(2)), 'h00);
        check(fb_code(4) == 8'hC0, "R3 code d4", int'(fb_code(4)), 'hC0);

        // R1: reset state
        do_reset();
        repeat (2) @(negedge clk);
        check(ref_tick == 0 && fb_tick == 0 && pix_tick == 0, "R1 ticks",
              int'({ref_tick, fb_tick, pix_tick}), 0);
        check(ref_clk == 0 && fb_clk == 0 && pix_clk == 0, "R1 clocks",
              int'({ref_clk, fb_clk, pix_clk}), 0);

        // R2 R3 R6 R9: periods across divisor ranges
        run_seg(1, 2, 1, 1, 4);
        run_seg(3, 3, 3, 2, 3);
        run_seg(64, 160, 8, 8, 3);
        run_seg(62, 159, 8, 1, 3);
        run_seg(63, 4, 5, 5, 3);
        run_seg(7, 17, 2, 1, 4);

        // R5: reload written mid-division applies at next terminal
        do_reset();
        wr(2'd0, {2'b00, ref_code(10)});
        q0.push_back('{10, "R5 old period"});
        q0.push_back('{10, "R5 period in progress"});
        q0.push_back('{4, "R5 new period"});
        q0.push_back('{4, "R5 new period"});
        @(negedge clk);
        ref_adv = 1'b1;
        while (tcnt[0] < 2) @(negedge clk);
        repeat (2) @(negedge clk);
        wr(2'd0, {2'b00, ref_code(4)});
        wait_empty(1'b0);

        // R7: transient post-divide write is never used
        do_reset();
        wr(2'd2, post_code(4, 4));
        q2.push_back('{16, "R7 before"});
        q2.push_back('{16, "R7 period in progress"});
        q2.push_back('{64, "R7 after"});
        q2.push_back('{64, "R7 after"});
        @(negedge clk);
        fb_adv = 1'b1;
        while (tcnt[2] < 2) @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = 2'd2;
        wr_data = 8'h09;
        @(negedge clk);
        wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        wait_empty(1'b0);

        // R8: half-rate VCO advances and a frozen reference
        do_reset();
        wr(2'd0, {2'b00, ref_code(5)});
        wr(2'd1, fb_code(6));
        wr(2'd2, post_code(2, 2));
        q0.push_back('{5, "R8 ref steady"});
        q0.push_back('{5, "R8 ref steady"});
        for (int i = 0; i < 3; i++) begin
            q1.push_back('{12, "R8 fb half rate"});
            q2.push_back('{8, "R8 post half rate"});
        end
        @(negedge clk);
        ref_adv = 1'b1;
        wait_empty(1'b1);
        fb_adv = 1'b0;
        while (!ref_tick) @(negedge clk);
        ref_adv = 1'b0;
        @(negedge clk);
        t0 = tcnt[0];
        c0 = ref_clk;
        repeat (60) @(negedge clk);
        check(tcnt[0] == t0, "R8 frozen ticks", tcnt[0], t0);
        check(ref_clk == c0, "R8 frozen clock", int'(ref_clk), int'(c0));

        summary();
    end

endmodule